// File: doc/BRIEF.md
# SPI Register Command Slave

This block is an SPI slave (mode 0) that gives a host processor access to a small bank of 8-bit registers. Each transaction opens with a command byte, shifted in most significant bit first while the active-low select is held low. The command byte names the kind of access, its direction and, for register accesses, a 6-bit address. A register access then carries exactly one data byte. On a read, the addressed register comes back on MISO during that byte. On a write, the byte is stored once all eight of its bits have arrived.

While the command byte is being shifted in, MISO returns a status byte rather than filler. A configuration bit held in the register bank chooses between the status input, captured when select falls, and a cleared byte. Commands that address the frame buffer or the SRAM are recognised and announced on a strobe together with their direction. Their data phase carries zeros and has no effect on the register bank.

SCLK, select and MOSI are brought into the system clock domain through a synchronizer chain. For this reason SCLK must stay below a quarter of the system clock rate.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, miso_oe and miso are low and cmd_stb is low. Every register reads 0x00 except the configuration register at address 0x3F, which reads 0x01.
- R2: MOSI is sampled on rising SCLK edges, MSB first. A command byte with bit 7 = 1 is a register access: bit 6 = 1 means write, bit 6 = 0 means read, and bits 5:0 give the address. For such a command, cmd_stb pulses once with cmd_mode = 2'b01 and cmd_wr equal to bit 6.
- R3: On a register read, the second byte on MISO is the addressed register's contents, MSB first.
- R4: On a register write, the second MOSI byte is stored into the addressed register, and MISO carries 0x00 during that byte.
- R5: The first MISO byte is the status input when bit 0 of the configuration register is 1. It is 0x00 when that bit is 0.
- R6: A command with bit 7 = 0 is announced by one cmd_stb pulse. cmd_mode is 2'b10 (frame buffer) when bit 5 = 1 and 2'b11 (SRAM) when bit 5 = 0, and cmd_wr equals bit 6. Its second MISO byte is 0x00, and no register changes.
- R7: The MOSI byte sent during the data phase of a register read is ignored: no register changes.
- R8: If select rises before all eight data bits of a write have arrived, the write is discarded and the register keeps its old value.
- R9: miso_oe is high only while select is low, and miso is low whenever miso_oe is low. The first status bit is driven as soon as the falling select is seen, and MISO changes only after falling SCLK edges.
- R10: Bytes after the second in a transaction return 0x00 on MISO and write nothing.
- R11: The status byte is captured when select falls. Changes on the status input later in the command byte do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from host |
| status_in | input | 8 | Status word returned in the command byte |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad |
| cmd_stb | output | 1 | One-cycle pulse when a command byte completes |
| cmd_mode | output | 2 | Decoded access kind: 01 register, 10 frame buffer, 11 SRAM |
| cmd_wr | output | 1 | Direction of the last command, 1 = write |

## Verification
A stale bit counter or byte index moves every MISO bit after it. The fault therefore shows within the next byte read back, as a shifted or zeroed value. A wrong write enable, or a wrong address compare in the register bank, only becomes visible when the damaged register is read in a later transaction. For this reason the sequence reads back every written location, and also neighbouring and aliased addresses, after aborted writes, reads with noisy MOSI, and frame-buffer or SRAM commands. A wrong status capture shows in the very first byte of the next transaction.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_REG  = 2'b01,
    ACC_FBUF = 2'b10,
    ACC_SRAM = 2'b11
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e  mode;
    logic       wr;
    logic [5:0] addr;
  } cmd_t;

  // bit 7 picks register access; otherwise bit 5 splits frame buffer from SRAM
  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.wr   = b[6];
    c.addr = b[5:0];
    if (b[7])      c.mode = ACC_REG;
    else if (b[5]) c.mode = ACC_FBUF;
    else           c.mode = ACC_SRAM;
    return c;
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_lvl,
  output logic mosi_s
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, mosi_q;
  logic [TOP:0] sclk_n, cs_nx, mosi_n;
  logic         sclk_d, cs_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        sclk_n = sclk;
        cs_nx  = cs_n;
        mosi_n = mosi;
      end
    end else begin : g_chain
      always_comb begin
        sclk_n = {sclk_q[TOP-1:0], sclk};
        cs_nx  = {cs_q[TOP-1:0], cs_n};
        mosi_n = {mosi_q[TOP-1:0], mosi};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= sclk_n;
      cs_q   <= cs_nx;
      mosi_q <= mosi_n;
      sclk_d <= sclk_q[TOP];
      cs_d   <= cs_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_q[TOP] & sclk_d;
  assign cs_fall   = ~cs_q[TOP] & cs_d;
  assign cs_rise   = cs_q[TOP] & ~cs_d;
  assign cs_lvl    = cs_q[TOP];
  assign mosi_s    = mosi_q[TOP];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int          AW        = 6,
  parameter int          DW        = 8,
  parameter int          CFG_ADDR  = 63,
  parameter logic [7:0]  CFG_RESET = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg_q
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] flat;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [DW-1:0] RV = (i == CFG_ADDR) ? DW'(CFG_RESET) : '0;
      logic          hit;
      logic [DW-1:0] q, q_n;

      assign hit = wr_en && (wr_addr == AW'(i));

      always_comb begin
        q_n = q;
        if (hit) q_n = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RV;
        else        q <= q_n;
      end

      assign flat[i*DW +: DW] = q;
    end
  endgenerate

  assign rd_data = flat[rd_addr*DW +: DW];
  assign cfg_q   = flat[CFG_ADDR*DW +: DW];

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_regif_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          mosi_s,
  input  logic [DW-1:0] status_byte,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          cmd_stb,
  output cmd_t          cmd,
  output logic          miso,
  output logic          miso_oe
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          active, active_n;
  logic [CW-1:0] bit_cnt, bit_cnt_n;
  logic [1:0]    byte_idx, byte_idx_n;
  logic [DW-2:0] rx_sr, rx_sr_n;
  logic [DW-1:0] tx_sr, tx_sr_n;
  logic          load_pend, load_pend_n;
  cmd_t          cmd_q, cmd_n;
  logic          stb_q, stb_n;
  logic          wr_q, wr_n;
  logic [DW-1:0] wdat_q, wdat_n;
  logic [DW-1:0] full_byte;
  logic [DW-1:0] next_tx;

  assign full_byte = {rx_sr, mosi_s};

  // data for the byte that follows a completed one
  always_comb begin
    next_tx = '0;
    if (byte_idx == 2'd1 && cmd_q.mode == ACC_REG && !cmd_q.wr)
      next_tx = rd_data;
  end

  always_comb begin
    active_n    = active;
    bit_cnt_n   = bit_cnt;
    byte_idx_n  = byte_idx;
    rx_sr_n     = rx_sr;
    tx_sr_n     = tx_sr;
    load_pend_n = load_pend;
    cmd_n       = cmd_q;
    stb_n       = 1'b0;
    wr_n        = 1'b0;
    wdat_n      = wdat_q;
    if (cs_rise) begin
      active_n    = 1'b0;
      bit_cnt_n   = '0;
      byte_idx_n  = 2'd0;
      tx_sr_n     = '0;
      load_pend_n = 1'b0;
    end else if (cs_fall) begin
      active_n    = 1'b1;
      bit_cnt_n   = '0;
      byte_idx_n  = 2'd0;
      tx_sr_n     = status_byte;
      load_pend_n = 1'b0;
    end else if (active) begin
      if (sclk_rise) begin
        rx_sr_n   = full_byte[DW-2:0];
        bit_cnt_n = bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          load_pend_n = 1'b1;
          case (byte_idx)
            2'd0: begin
              cmd_n      = decode_cmd(full_byte);
              stb_n      = 1'b1;
              byte_idx_n = 2'd1;
            end
            2'd1: begin
              if (cmd_q.mode == ACC_REG && cmd_q.wr) begin
                wr_n   = 1'b1;
                wdat_n = full_byte;
              end
              byte_idx_n = 2'd2;
            end
            default: byte_idx_n = 2'd2;
          endcase
        end
      end
      if (sclk_fall) begin
        if (load_pend) begin
          tx_sr_n     = next_tx;
          load_pend_n = 1'b0;
        end else begin
          tx_sr_n = {tx_sr[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bit_cnt   <= '0;
      byte_idx  <= 2'd0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      load_pend <= 1'b0;
      cmd_q     <= '{mode: ACC_NONE, wr: 1'b0, addr: '0};
      stb_q     <= 1'b0;
      wr_q      <= 1'b0;
      wdat_q    <= '0;
    end else begin
      active    <= active_n;
      bit_cnt   <= bit_cnt_n;
      byte_idx  <= byte_idx_n;
      rx_sr     <= rx_sr_n;
      tx_sr     <= tx_sr_n;
      load_pend <= load_pend_n;
      cmd_q     <= cmd_n;
      stb_q     <= stb_n;
      wr_q      <= wr_n;
      wdat_q    <= wdat_n;
    end
  end

  assign rd_addr = cmd_q.addr;
  assign wr_addr = cmd_q.addr;
  assign wr_en   = wr_q;
  assign wr_data = wdat_q;
  assign cmd_stb = stb_q;
  assign cmd     = cmd_q;
  assign miso    = active & tx_sr[DW-1];
  assign miso_oe = active;

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regif_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         CFG_ADDR    = 63,
  parameter logic [7:0] CFG_RESET   = 8'h01,
  parameter int         STAT_BIT    = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] status_in,
  output logic       miso,
  output logic       miso_oe,
  output logic       cmd_stb,
  output logic [1:0] cmd_mode,
  output logic       cmd_wr
);

  localparam int AW = 6;
  localparam int DW = 8;

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          sclk_rise, sclk_fall, cs_fall, cs_rise, cs_s, mosi_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data, cfg_q, status_byte;
  logic          wr_en;
  cmd_t          cmd;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .cs_lvl   (cs_s),
    .mosi_s   (mosi_s)
  );

  assign status_byte = cfg_q[STAT_BIT] ? status_in : '0;

  spi_shift_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .mosi_s     (mosi_s),
    .status_byte(status_byte),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmd_stb    (cmd_stb),
    .cmd        (cmd),
    .miso       (miso),
    .miso_oe    (miso_oe)
  );

  spi_reg_bank #(
    .AW(AW), .DW(DW), .CFG_ADDR(CFG_ADDR), .CFG_RESET(CFG_RESET)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .cfg_q  (cfg_q)
  );

  assign cmd_mode = cmd.mode;
  assign cmd_wr   = cmd.wr;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_lvl,
  input logic       sclk_fall,
  input logic       miso,
  input logic       miso_oe,
  input logic       cmd_stb,
  input logic [1:0] cmd_mode,
  input logic       cmd_wr,
  input logic       wr_en
);

  // R9: a high select seen inside the block turns the pad off next cycle
  a_r9_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> !miso_oe);

  // R9: a disabled pad carries a low level
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  // R9: inside a transaction MISO moves only after a falling SCLK
  a_r9_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(sclk_fall)) |-> $stable(miso));

  // R6: the command strobe lasts a single cycle
  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R4: stores happen only under a register write command
  a_r4_write_reg_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cmd_mode == 2'b01 && cmd_wr));

  // R10: one store per transaction, never back to back
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cs_lvl   (cs_s),
  .sclk_fall(sclk_fall),
  .miso     (miso),
  .miso_oe  (miso_oe),
  .cmd_stb  (cmd_stb),
  .cmd_mode (cmd_mode),
  .cmd_wr   (cmd_wr),
  .wr_en    (wr_en)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic [7:0] status_in = 8'hA5;
  logic       miso, miso_oe, cmd_stb, cmd_wr;
  logic [1:0] cmd_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] model [64];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  int         stb_count = 0;
  logic [1:0] last_mode = 2'b00;
  logic       last_wr   = 1'b0;

  always #4 clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .status_in(status_in), .miso(miso), .miso_oe(miso_oe),
    .cmd_stb(cmd_stb), .cmd_mode(cmd_mode), .cmd_wr(cmd_wr)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // monitor: assembles MISO bytes on rising SCLK and pops the scoreboard
  int         mon_cnt = 0;
  logic [7:0] mon_sr  = 8'h00;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      mon_cnt = 0;
    end else begin
      mon_sr = {mon_sr[6:0], miso};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2 unexpected byte actual=%02h expected=none", mon_sr);
        end else begin
          check(tag_q.pop_front(), mon_sr, exp_q.pop_front());
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmd_stb) begin
      stb_count++;
      last_mode = cmd_mode;
      last_wr   = cmd_wr;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_low();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  function automatic logic [7:0] stat_exp();
    return model[63][0] ? status_in : 8'h00;
  endfunction

  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    push(stat_exp(), "R5 status on write");
    push(8'h00, "R4 write data phase");
    sel_low();
    send_bits({2'b11, a}, 8);
    send_bits(d, 8);
    sel_high();
    model[a] = d;
  endtask

  task automatic reg_read(input logic [5:0] a, input logic [7:0] noise, input string tag);
    push(stat_exp(), "R5 status on read");
    push(model[a], tag);
    sel_low();
    send_bits({2'b10, a}, 8);
    send_bits(noise, 8);
    sel_high();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    model[63] = 8'h01;
    wait_clk(5);
    check("R1 reset miso_oe", {7'd0, miso_oe}, 8'h00);
    check("R1 reset miso", {7'd0, miso}, 8'h00);
    check("R1 reset cmd_stb", {7'd0, cmd_stb}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset contents, R3 read path
    reg_read(6'd0, 8'h00, "R1 reg0 reset value");
    reg_read(6'd63, 8'h00, "R1 cfg reset value");
    check("R2 read strobe mode", {6'd0, last_mode}, 8'h01);
    check("R2 read strobe dir", {7'd0, last_wr}, 8'h00);

    // R9 first status bit as soon as select falls
    sel_low();
    check("R9 miso_oe during select", {7'd0, miso_oe}, 8'h01);
    check("R9 first status bit", {7'd0, miso}, {7'd0, status_in[7]});
    cs_n = 1'b1;
    wait_clk(2*HALF);
    check("R9 miso_oe after select", {7'd0, miso_oe}, 8'h00);

    // R4, R3, R2 writes across the address range
    stb_count = 0;
    reg_write(6'd5, 8'h3C);
    check("R2 write strobe count", stb_count[7:0], 8'h01);
    check("R2 write strobe mode", {6'd0, last_mode}, 8'h01);
    check("R2 write strobe dir", {7'd0, last_wr}, 8'h01);
    reg_write(6'd0, 8'h81);
    reg_write(6'd62, 8'h7E);
    reg_read(6'd5, 8'h00, "R3 readback addr 5");
    reg_read(6'd0, 8'h00, "R3 readback addr 0");
    reg_read(6'd62, 8'h00, "R3 readback addr 62");
    reg_read(6'd4, 8'h00, "R2 neighbour addr 4 untouched");

    // R7 read with noisy MOSI data byte
    reg_read(6'd5, 8'hFF, "R7 read with noise");
    reg_read(6'd5, 8'h00, "R7 register unchanged");

    // R8 aborted write
    push(stat_exp(), "R5 status on aborted write");
    sel_low();
    send_bits({2'b11, 6'd5}, 8);
    send_bits(8'hFF, 4);
    sel_high();
    reg_read(6'd5, 8'h00, "R8 aborted write discarded");

    // R6 frame buffer and SRAM commands
    stb_count = 0;
    push(stat_exp(), "R5 status on frame buffer");
    push(8'h00, "R6 frame buffer data phase");
    sel_low();
    send_bits(8'h60, 8);
    send_bits(8'h55, 8);
    sel_high();
    check("R6 fbuf mode", {6'd0, last_mode}, 8'h02);
    check("R6 fbuf dir", {7'd0, last_wr}, 8'h01);
    push(stat_exp(), "R5 status on sram");
    push(8'h00, "R6 sram data phase");
    sel_low();
    send_bits(8'h00, 8);
    send_bits(8'hAA, 8);
    sel_high();
    check("R6 sram mode", {6'd0, last_mode}, 8'h03);
    check("R6 sram dir", {7'd0, last_wr}, 8'h00);
    check("R6 strobe count", stb_count[7:0], 8'h02);
    reg_read(6'd32, 8'h00, "R6 addr 32 untouched");
    reg_read(6'd0, 8'h00, "R6 addr 0 untouched");

    // R10 bytes past the second
    push(stat_exp(), "R5 status on long write");
    push(8'h00, "R4 long write data phase");
    push(8'h00, "R10 third byte zero");
    sel_low();
    send_bits({2'b11, 6'd7}, 8);
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    sel_high();
    model[7] = 8'h11;
    reg_read(6'd7, 8'h00, "R10 only second byte stored");
    push(stat_exp(), "R5 status on long read");
    push(model[62], "R3 long read data");
    push(8'h00, "R10 read third byte zero");
    sel_low();
    send_bits({2'b10, 6'd62}, 8);
    send_bits(8'h00, 16);
    sel_high();

    // R11 status captured at select fall
    status_in = 8'h3C;
    push(8'h3C, "R11 status captured at fall");
    push(model[5], "R3 read after status change");
    sel_low();
    status_in = 8'hC3;
    send_bits({2'b10, 6'd5}, 8);
    send_bits(8'h00, 8);
    sel_high();

    // R5 cleared status mode, then restore
    reg_write(6'd63, 8'h00);
    reg_read(6'd5, 8'h00, "R5 cleared status read");
    reg_write(6'd63, 8'h01);
    reg_read(6'd63, 8'h00, "R5 cfg restored");

    wait_clk(4);
    check("R2 scoreboard drained", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule